// File: doc/BRIEF.md
# Quadrature Dial Counter

This block turns the two phase outputs of a rotary shaft encoder into a two-digit decimal position value. Both phases pass through a synchroniser first. A decoder then compares each new phase pair with the previous one. Every legal change of the pair is one step, so the block resolves four steps per full phase cycle. The order in which the phases change sets the direction of each step.

Each step moves a BCD counter up or down by one. The counter runs from 00 to 31 and wraps at both ends. A step is counted only while two separate enable inputs are both high. The tens and units digits are brought out directly, ready to feed seven-segment decoders.

Top module: `qdial_counter`

## Requirements
- R1: A synchronous active-high reset sets both digits to 0. It also takes 00 as the stored phase reference, with A as bit 1 and B as bit 0.
- R2: The outputs are always valid BCD. The units digit stays in 0..9, the tens digit stays in 0..3, and the combined value never exceeds 31.
- R3: A phase change along the order 00, 01, 11, 10, 00 (written {A,B}) raises the value by exactly one for each change.
- R4: A phase change along the reverse order 00, 10, 11, 01, 00 lowers the value by exactly one for each change.
- R5: An up step taken at 31 gives 00.
- R6: A down step taken at 00 gives 31.
- R7: The units digit carries into the tens digit from 09 to 10, and borrows from it from 10 to 09.
- R8: A change in which both phases flip between two synchronised samples leaves the value unchanged.
- R9: While either enable is low, phase changes leave the value unchanged. The phase reference still follows the inputs, so the first enabled step afterwards is judged against the latest phase pair.
- R10: A phase change present at the inputs reaches the outputs on the third rising clock edge after it appears. The value is unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cnt_en_a | input | 1 | First count enable |
| cnt_en_b | input | 1 | Second count enable |
| tens_o | output | 4 | Tens digit, BCD |
| units_o | output | 4 | Units digit, BCD |

## Verification
A table walks the encoder forward through two full phase cycles, across the 09/10 digit boundary, and then backwards. Forward and reverse steps must move the value in opposite directions. The same table inserts double-phase jumps from two different states, and steps with each enable low on its own. These separate a dropped step from a miscounted step, and show that a held count still tracks the phase reference. Directed tests then cover both wrap points, a 70-step forward sweep against a modulo-32 model, the exact output latency, and reset in the middle of a count.

// File: rtl/qdial_pkg.sv
package qdial_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } dial_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_t;

    // Forward successor of a phase pair {A,B} in the Gray order 00,01,11,10.
    function automatic logic [1:0] phase_succ(input logic [1:0] ph);
        case (ph)
            2'b00:   phase_succ = 2'b01;
            2'b01:   phase_succ = 2'b11;
            2'b11:   phase_succ = 2'b10;
            default: phase_succ = 2'b00;
        endcase
    endfunction

    function automatic int unsigned dial_value(input dial_t d);
        dial_value = int'(d.tens) * 10 + int'(d.units);
    endfunction

endpackage

// File: rtl/qdial_sync.sv
module qdial_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdial_decode.sv
module qdial_decode
    import qdial_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] phase_i,
    output step_t      step_o
);
    logic [1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 2'b00;
        else     ref_q <= phase_i;
    end

    always_comb begin
        step_o = STEP_NONE;
        if (phase_i == phase_succ(ref_q))
            step_o = STEP_UP;
        else if (ref_q == phase_succ(phase_i))
            step_o = STEP_DOWN;
    end

    // R8: a double flip of the phases never yields a step
    p_no_step_on_jump_r8: assert property (@(posedge clk) disable iff (rst)
        ((phase_i ^ ref_q) == 2'b11) |-> (step_o == STEP_NONE));
endmodule

// File: rtl/qdial_bcd_counter.sv
module qdial_bcd_counter
    import qdial_pkg::*;
#(
    parameter int MAX_COUNT = 31
) (
    input  logic  clk,
    input  logic  rst,
    input  step_t step_i,
    input  logic  enable_i,
    output dial_t dial_o
);
    localparam int   SPAN       = MAX_COUNT + 1;
    localparam bcd_t TOP_TENS   = bcd_t'(MAX_COUNT / 10);
    localparam bcd_t TOP_UNITS  = bcd_t'(MAX_COUNT % 10);

    dial_t cnt_q, cnt_d;
    logic  at_top, at_zero;

    assign at_top  = (cnt_q.tens == TOP_TENS) && (cnt_q.units == TOP_UNITS);
    assign at_zero = (cnt_q.tens == 4'd0) && (cnt_q.units == 4'd0);

    always_comb begin
        cnt_d = cnt_q;
        if (enable_i && step_i == STEP_UP) begin
            if (at_top) begin
                cnt_d = '0;
            end else if (cnt_q.units == 4'd9) begin
                cnt_d.units = 4'd0;
                cnt_d.tens  = cnt_q.tens + 4'd1;
            end else begin
                cnt_d.units = cnt_q.units + 4'd1;
            end
        end else if (enable_i && step_i == STEP_DOWN) begin
            if (at_zero) begin
                cnt_d.tens  = TOP_TENS;
                cnt_d.units = TOP_UNITS;
            end else if (cnt_q.units == 4'd0) begin
                cnt_d.units = 4'd9;
                cnt_d.tens  = cnt_q.tens - 4'd1;
            end else begin
                cnt_d.units = cnt_q.units - 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign dial_o = cnt_q;

    // R2: digits stay BCD and inside the span
    p_valid_bcd_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q.units <= 4'd9) && (dial_value(cnt_q) <= MAX_COUNT));

    // R3 and R5: an enabled up step adds one modulo the span
    p_up_by_one_r3: assert property (@(posedge clk) disable iff (rst)
        (enable_i && step_i == STEP_UP) |=>
        (dial_value(cnt_q) == (dial_value($past(cnt_q)) + 1) % SPAN));

    // R4 and R6: an enabled down step subtracts one modulo the span
    p_down_by_one_r4: assert property (@(posedge clk) disable iff (rst)
        (enable_i && step_i == STEP_DOWN) |=>
        (dial_value(cnt_q) == (dial_value($past(cnt_q)) + SPAN - 1) % SPAN));

    // R9: no enable, no movement
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> $stable(cnt_q));
endmodule

// File: rtl/qdial_counter.sv
module qdial_counter
    import qdial_pkg::*;
#(
    parameter int MAX_COUNT   = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       cnt_en_a,
    input  logic       cnt_en_b,
    output logic [3:0] tens_o,
    output logic [3:0] units_o
);
    logic [1:0] phase_sync;
    step_t      step;
    dial_t      dial;

    qdial_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({enc_a, enc_b}),
        .sync_o  (phase_sync)
    );

    qdial_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_sync),
        .step_o  (step)
    );

    qdial_bcd_counter #(.MAX_COUNT(MAX_COUNT)) u_count (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .enable_i (cnt_en_a & cnt_en_b),
        .dial_o   (dial)
    );

    assign tens_o  = dial.tens;
    assign units_o = dial.units;

    // R1: the cycle after reset shows 00
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (tens_o == 4'd0 && units_o == 4'd0));
endmodule

// File: tb/qdial_counter_tb.sv
module qdial_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0, enc_b = 1'b0;
    logic       cnt_en_a = 1'b1, cnt_en_b = 1'b1;
    logic [3:0] tens_o, units_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    qdial_counter u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .cnt_en_a(cnt_en_a), .cnt_en_b(cnt_en_b),
        .tens_o(tens_o), .units_o(units_o)
    );

    typedef struct packed {
        logic [1:0] ab;
        logic [1:0] en;
        logic [3:0] tens;
        logic [3:0] units;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 2'b11, 4'd0, 4'd1},  // R3 forward
        '{2'b11, 2'b11, 4'd0, 4'd2},  // R3
        '{2'b10, 2'b11, 4'd0, 4'd3},  // R3
        '{2'b00, 2'b11, 4'd0, 4'd4},  // R3
        '{2'b01, 2'b11, 4'd0, 4'd5},
        '{2'b11, 2'b11, 4'd0, 4'd6},
        '{2'b10, 2'b11, 4'd0, 4'd7},
        '{2'b00, 2'b11, 4'd0, 4'd8},
        '{2'b01, 2'b11, 4'd0, 4'd9},
        '{2'b11, 2'b11, 4'd1, 4'd0},  // R7 carry
        '{2'b01, 2'b11, 4'd0, 4'd9},  // R4 reverse, R7 borrow
        '{2'b00, 2'b11, 4'd0, 4'd8},  // R4
        '{2'b10, 2'b11, 4'd0, 4'd7},  // R4
        '{2'b11, 2'b10, 4'd0, 4'd7},  // R9 second enable low
        '{2'b10, 2'b01, 4'd0, 4'd7},  // R9 first enable low
        '{2'b00, 2'b11, 4'd0, 4'd8},  // R9 reference followed: 10->00 is up
        '{2'b11, 2'b11, 4'd0, 4'd8},  // R8 jump 00->11
        '{2'b10, 2'b11, 4'd0, 4'd9},  // R3 from 11
        '{2'b01, 2'b11, 4'd0, 4'd9},  // R8 jump 10->01
        '{2'b00, 2'b11, 4'd0, 4'd8}   // R4 from 01
    };

    task automatic check(input string req, input logic [3:0] et, input logic [3:0] eu);
        checks++;
        if (tens_o !== et || units_o !== eu) begin
            errors++;
            $display("FAIL %s: got %0d%0d expected %0d%0d", req, tens_o, units_o, et, eu);
        end
    endtask

    // Drive a phase pair, then sample one ns after the third rising edge.
    task automatic drive(input logic [1:0] ab, input logic [1:0] en);
        @(negedge clk);
        {enc_a, enc_b} = ab;
        {cnt_en_a, cnt_en_b} = en;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {enc_a, enc_b} = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] ph;
        int model;

        do_reset();
        check("R1 reset", 4'd0, 4'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].ab, VECS[i].en);
            check($sformatf("table[%0d]", i), VECS[i].tens, VECS[i].units);
        end

        // R1: reset in mid count
        do_reset();
        check("R1 mid-count reset", 4'd0, 4'd0);

        // R6: down from 00 wraps to 31; R5: up from 31 wraps to 00
        drive(2'b10, 2'b11);
        check("R6 down wrap", 4'd3, 4'd1);
        drive(2'b00, 2'b11);
        check("R5 up wrap", 4'd0, 4'd0);

        // R10: latency of exactly three rising edges
        @(negedge clk);
        {enc_a, enc_b} = 2'b01;
        repeat (2) @(posedge clk);
        #1;
        check("R10 two edges", 4'd0, 4'd0);
        @(posedge clk);
        #1;
        check("R10 third edge", 4'd0, 4'd1);

        // R2, R3, R5: long forward sweep against a modulo-32 model
        ph = 2'b01;
        model = 1;
        for (int k = 0; k < 70; k++) begin
            case (ph)
                2'b00:   ph = 2'b01;
                2'b01:   ph = 2'b11;
                2'b11:   ph = 2'b10;
                default: ph = 2'b00;
            endcase
            model = (model + 1) % 32;
            drive(ph, 2'b11);
            check("R2 sweep", 4'(model / 10), 4'(model % 10));
        end

        // R9: both enables low, then step counts from the new reference
        drive(2'b00, 2'b00);
        check("R9 both low", 4'(model / 10), 4'(model % 10));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule